// File: doc/BRIEF.md
# Decimal Up/Down Digit Counter

This block holds a single decimal digit and moves it by one each clock while its enable is high. A direction input selects counting upward or downward. Counting upward, the digit wraps from 9 back to 0. Counting downward, it wraps from 0 back to 9. A synchronous initialise input loads the start value for the current direction: 0 when counting upward and 9 when counting downward. Initialise overrides enable.

Each wrap raises a one-cycle terminal strobe, so a neighbouring digit can use the strobe as its own enable. The reset is asynchronous and active-low. It is released through an internal synchroniser, and it leaves the digit at 0.

Top module: `dec_updn_digit`

## Requirements
- R1: While rst_ni is low, and after its release until the first enabled step, digit_o is 0 and wrap_o is 0.
- R2: With init_i low and en_i low, a clock edge leaves digit_o unchanged and wrap_o low.
- R3: With init_i low, en_i high and up_i high (up is 1, down is 0), a digit below 9 increases by one at the clock edge, and wrap_o stays low.
- R4: With init_i low, en_i high and up_i low, a digit above 0 decreases by one at the clock edge, and wrap_o stays low.
- R5: An enabled upward step from 9 gives 0, and wrap_o is high for that one cycle.
- R6: An enabled downward step from 0 gives 9, and wrap_o is high for that one cycle.
- R7: init_i high with up_i high loads 0 at the clock edge, whatever the current digit.
- R8: init_i high with up_i low loads 9 at the clock edge, whatever the current digit.
- R9: init_i takes priority over en_i, and a load through init_i never raises wrap_o.
- R10: digit_o never takes a value from 10 to 15.
- R11: wrap_o is high only in the cycle after an enabled step that wrapped, and it returns low on the next edge unless that step wraps again.
- R12: A change of up_i in the middle of a count takes effect on the very next enabled step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| up_i | input | 1 | Count direction: 1 counts upward, 0 counts downward |
| init_i | input | 1 | Synchronous load of the start value for the current direction |
| en_i | input | 1 | Step enable |
| digit_o | output | 4 | Current digit, binary-coded 0 to 9 |
| wrap_o | output | 1 | One-cycle strobe after a wrapping step (carry or borrow) |

## Verification
The hardest case to reach is a wrap that follows a direction change. For example, the bench counts upward to 9, then turns the count downward without stepping, then upward again. It must show that only the step taken from 9 in the upward direction wraps. The stimulus reaches this with directed runs that reverse up_i at 9 and at 0, and in the middle of the range. It also holds en_i low at 9 and at 0 to show that no strobe appears without a step. It also asserts init_i together with en_i at both ends of the range, so that priority and the absent strobe can be seen at the ports.

// File: rtl/dec_ctr_pkg.sv
package dec_ctr_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/dec_rst_sync.sv
module dec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/dec_step_logic.sv
module dec_step_logic
  import dec_ctr_pkg::*;
#(
  parameter digit_t LAST_VAL = digit_t'(9)
) (
  input  digit_t cur_i,
  input  logic   up_i,
  input  logic   init_i,
  input  logic   en_i,
  output digit_t nxt_o,
  output logic   wrap_o
);
  localparam digit_t FIRST_VAL = '0;

  logic at_top, at_bottom;
  assign at_top    = (cur_i == LAST_VAL);
  assign at_bottom = (cur_i == FIRST_VAL);

  always_comb begin
    nxt_o  = cur_i;
    wrap_o = 1'b0;
    if (init_i) begin
      nxt_o = (dir_e'(up_i) == DIR_UP) ? FIRST_VAL : LAST_VAL;
    end else if (en_i) begin
      if (dir_e'(up_i) == DIR_UP) begin
        nxt_o  = at_top ? FIRST_VAL : digit_t'(cur_i + 1'b1);
        wrap_o = at_top;
      end else begin
        nxt_o  = at_bottom ? LAST_VAL : digit_t'(cur_i - 1'b1);
        wrap_o = at_bottom;
      end
    end
  end
endmodule

// File: rtl/dec_updn_digit.sv
module dec_updn_digit
  import dec_ctr_pkg::*;
#(
  parameter int     SYNC_STAGES = 2,
  parameter digit_t LAST_VAL    = digit_t'(9)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               up_i,
  input  logic               init_i,
  input  logic               en_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               wrap_o
);
  logic   rst_n;
  digit_t digit_q, digit_d;
  logic   wrap_q, wrap_d;

  dec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  dec_step_logic #(.LAST_VAL(LAST_VAL)) u_step (
    .cur_i  (digit_q),
    .up_i   (up_i),
    .init_i (init_i),
    .en_i   (en_i),
    .nxt_o  (digit_d),
    .wrap_o (wrap_d)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      digit_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      digit_q <= digit_d;
      wrap_q  <= wrap_d;
    end
  end

  assign digit_o = digit_q;
  assign wrap_o  = wrap_q;

  // R10: range of the held digit
  a_r10_digit_range: assert property (@(posedge clk_i) disable iff (!rst_n)
    digit_q <= LAST_VAL);

  // R2: hold while idle
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!init_i && !en_i) |=> ($stable(digit_q) && !wrap_q));

  // R7: load while counting upward
  a_r7_init_up: assert property (@(posedge clk_i) disable iff (!rst_n)
    (init_i && up_i) |=> (digit_q == '0 && !wrap_q));

  // R8, R9: load while counting downward
  a_r8_init_down: assert property (@(posedge clk_i) disable iff (!rst_n)
    (init_i && !up_i) |=> (digit_q == LAST_VAL && !wrap_q));

  // R3: plain upward step
  a_r3_up_step: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!init_i && en_i && up_i && digit_q != LAST_VAL)
      |=> (digit_q == digit_t'($past(digit_q) + 1'b1) && !wrap_q));

  // R4: plain downward step
  a_r4_down_step: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!init_i && en_i && !up_i && digit_q != '0)
      |=> (digit_q == digit_t'($past(digit_q) - 1'b1) && !wrap_q));

  // R5: upward wrap with strobe
  a_r5_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!init_i && en_i && up_i && digit_q == LAST_VAL) |=> (digit_q == '0 && wrap_q));

  // R6: downward wrap with strobe
  a_r6_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!init_i && en_i && !up_i && digit_q == '0) |=> (digit_q == LAST_VAL && wrap_q));

  // R11: strobe lands only on a wrapped value
  a_r11_strobe_value: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap_q |-> (digit_q == '0 || digit_q == LAST_VAL));
endmodule

// File: tb/tb_dec_updn_digit.sv
`timescale 1ns/1ps
module tb_dec_updn_digit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       up, init, en;
  logic [3:0] digit;
  logic       wrap;

  int total = 0;
  int bad   = 0;
  int exp_d = 0;
  bit exp_w = 1'b0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dec_updn_digit dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .up_i    (up),
    .init_i  (init),
    .en_i    (en),
    .digit_o (digit),
    .wrap_o  (wrap)
  );

  task automatic check(input string tag);
    total++;
    if (digit !== 4'(exp_d) || wrap !== exp_w || digit > 4'd9) begin
      bad++;
      $display("FAIL %s: digit=%0d wrap=%0b expected digit=%0d wrap=%0b",
               tag, digit, wrap, exp_d, exp_w);
    end
  endtask

  // One clock: drive after a falling edge, sample 1 ns after the rising edge.
  task automatic tick(input bit e, input bit i, input bit u, input string tag);
    en = e; init = i; up = u;
    exp_w = 1'b0;
    if (i) exp_d = u ? 0 : 9;
    else if (e) begin
      if (u) begin
        if (exp_d == 9) begin exp_d = 0; exp_w = 1'b1; end
        else exp_d = exp_d + 1;
      end else begin
        if (exp_d == 0) begin exp_d = 9; exp_w = 1'b1; end
        else exp_d = exp_d - 1;
      end
    end
    @(posedge clk); #1;
    check(tag);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; init = 1'b0; up = 1'b1;
    repeat (3) @(negedge clk);
    exp_d = 0; exp_w = 1'b0;
    check("R1 in reset");
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b0, 1'b1, "R1 after release");
  endtask

  task automatic t_count_up();
    for (int k = 0; k < 9; k++) tick(1'b1, 1'b0, 1'b1, "R3 up step");
    tick(1'b0, 1'b0, 1'b1, "R2 hold at 9 no strobe");
    tick(1'b1, 1'b0, 1'b1, "R5 up wrap");
    tick(1'b1, 1'b0, 1'b1, "R11 strobe clears");
  endtask

  task automatic t_count_down();
    tick(1'b1, 1'b1, 1'b0, "R8 init down");
    for (int k = 0; k < 9; k++) tick(1'b1, 1'b0, 1'b0, "R4 down step");
    tick(1'b0, 1'b0, 1'b0, "R2 hold at 0 no strobe");
    tick(1'b1, 1'b0, 1'b0, "R6 down wrap");
    tick(1'b1, 1'b0, 1'b0, "R11 strobe clears");
  endtask

  task automatic t_init_priority();
    tick(1'b1, 1'b1, 1'b1, "R7 init up with enable");
    tick(1'b1, 1'b1, 1'b1, "R9 repeated init no strobe");
    tick(1'b1, 1'b1, 1'b0, "R9 init down from 0 no strobe");
    tick(1'b0, 1'b1, 1'b1, "R7 init up without enable");
    tick(1'b1, 1'b1, 1'b0, "R8 init down");
    tick(1'b0, 1'b0, 1'b1, "R2 hold");
  endtask

  task automatic t_dir_change();
    tick(1'b1, 1'b1, 1'b1, "R7 start at 0");
    for (int k = 0; k < 4; k++) tick(1'b1, 1'b0, 1'b1, "R12 up leg");
    tick(1'b1, 1'b0, 1'b0, "R12 reverse mid count");
    tick(1'b1, 1'b0, 1'b1, "R12 forward again");
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, 1'b1, "R12 up to 9");
    tick(1'b1, 1'b0, 1'b0, "R12 down from 9 no strobe");
    tick(1'b1, 1'b0, 1'b1, "R12 back up to 9");
    tick(1'b1, 1'b0, 1'b1, "R5 wrap after reversals");
    tick(1'b1, 1'b0, 1'b0, "R6 immediate reverse wraps down");
    tick(1'b1, 1'b0, 1'b1, "R5 immediate reverse wraps up");
  endtask

  initial begin
    t_reset();
    t_count_up();
    t_count_down();
    t_init_priority();
    t_dir_change();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule